// File: doc/BRIEF.md
# Field-Encoded Programmable Clock Divider

This block derives a slower clock from a reference clock. The divide ratio comes from a bit field inside a 32-bit control word. The field's position (a shift) and size (a width) are elaboration parameters. A second parameter chooses how the raw field value is turned into a ratio. There are five choices: value plus one, value taken as is, two to the power of the value, value with zero standing for the largest ratio, or a short lookup list of value/ratio pairs.

The control word is written through a plain write strobe with 32 data bits, and it reads back at all times. It has two write styles:
- **Field-only:** a write touches nothing but the divider field.
- **Half-word mask:** the upper sixteen data bits of each write act as per-bit enables for the lower sixteen bits.

A mask configuration whose field does not fit inside the lower half-word is flagged. The block then refuses every write to it.

The output clock changes ratio only at a period boundary. A ratio of one, or an unresolvable ratio of zero, routes the reference clock straight to the output. A zero ratio also raises a flag.

Top module: `fieldclk_div`

## Requirements
- R1: With the plus-one encoding, the output period is the field value plus one reference cycles. All ones in a 3-bit field therefore gives 8.
- R2: With the as-is encoding, the period equals the field value. Zero resolves to ratio 0.
- R3: With the power-of-two encoding, the period is 2 to the power of the field value. A 3-bit field of 7 gives 128.
- R4: With the zero-is-maximum encoding, field 0 gives a period of two to the field width (8 for 3 bits). Any other value gives that value.
- R5: With the lookup encoding, the first matching pair supplies the ratio. The default pairs are 0→2, 1→3, 4→6 and 6→12. A value with no pair resolves to 0.
- R6: While the active ratio is 0, `zero_div` is 1 and `clk_out` follows `clk`. A ratio of 1 also follows `clk`, but `zero_div` stays 0.
- R7: Only bits SHIFT+WIDTH-1 down to SHIFT decode the ratio. In field-only mode, a write replaces exactly those bits, and every other bit of `rd_data` keeps its reset value.
- R8: In half-word mask mode, write-data bit 16+i enables an update of control bit i, for i from 0 to 15. Control bits 31:16 never change.
- R9: In mask mode with SHIFT+WIDTH above 16, `cfg_err` is 1 and writes leave `rd_data` at its reset value.
- R10: A newly written ratio is loaded only when the current output period ends. It is seen no earlier than the second clock edge after the write.
- R11: For a ratio N of at least 2, each period starts high. It stays high for ceil(N/2) reference cycles and low for floor(N/2).
- R12: While `rst` is held, `rd_data` equals the reset word, and the output sits at the start of the high phase of the reset ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data (upper half doubles as bit enables in mask mode) |
| rd_data | output | 32 | Current control word |
| clk_out | output | 1 | Divided clock |
| zero_div | output | 1 | Active ratio resolved to zero |
| cfg_err | output | 1 | Illegal mask-mode field placement |

## Verification
All internal state surfaces at the ports, so errors appear quickly:
- **Wrong field decode:** shows up as a wrong `clk_out` level within one output period of the next boundary.
- **Corrupted phase counter:** shows up on the next half-cycle as a high/low sample that disagrees with the modelled phase.
- **Wrong write merge:** appears on `rd_data` one edge after the write.
- **Early ratio load:** visible inside the same period as a truncated high or low phase.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int CTRL_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        ENC_PLUS1,
        ENC_ONEB,
        ENC_POW2,
        ENC_MAXZ,
        ENC_TABLE
    } fcd_enc_e;

    typedef enum logic {
        WR_FIELD,
        WR_HALFMASK
    } fcd_wmode_e;

    typedef struct packed {
        logic              en;
        logic [CTRL_W-1:0] data;
    } fcd_wr_t;

    // Bits needed to hold the largest ratio an encoding can produce.
    function automatic int ratio_bits(fcd_enc_e enc, int width, int tbl_dw);
        int r;
        case (enc)
            ENC_POW2:  r = 1 << width;
            ENC_ONEB:  r = width;
            ENC_TABLE: r = tbl_dw;
            default:   r = width + 1;
        endcase
        return (r < 2) ? 2 : r;
    endfunction

    function automatic logic cfg_bad(fcd_wmode_e m, int shift, int width);
        return (shift + width > CTRL_W) || ((m == WR_HALFMASK) && (shift + width > HALF_W));
    endfunction

endpackage

// File: rtl/fcd_ctrl_reg.sv
module fcd_ctrl_reg
    import fcd_pkg::*;
#(
    parameter int                  SHIFT   = 4,
    parameter int                  WIDTH   = 3,
    parameter fcd_wmode_e          WMODE   = WR_FIELD,
    parameter logic [CTRL_W-1:0]   RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  fcd_wr_t           wr,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              cfg_err_o
);

    localparam logic [CTRL_W-1:0] FMASK = ((CTRL_W'(1) << WIDTH) - CTRL_W'(1)) << SHIFT;
    localparam logic              BAD   = cfg_bad(WMODE, SHIFT, WIDTH);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] ctrl_d;

    generate
        if (WMODE == WR_HALFMASK) begin : g_halfmask
            always_comb begin
                ctrl_d = ctrl_q;
                for (int i = 0; i < HALF_W; i++) begin
                    if (wr.data[HALF_W + i]) ctrl_d[i] = wr.data[i];
                end
            end

            // R8: bits without an enable and the whole upper half hold across a write
            p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
                wr.en |=> ((((ctrl_q[HALF_W-1:0] ^ $past(ctrl_q[HALF_W-1:0]))
                              & ~$past(wr.data[CTRL_W-1:HALF_W])) == '0)
                           && (ctrl_q[CTRL_W-1:HALF_W] == RST_VAL[CTRL_W-1:HALF_W])));
        end else begin : g_field
            assign ctrl_d = (ctrl_q & ~FMASK) | (wr.data & FMASK);

            // R7: bits outside the field never leave their reset value
            p_field_only_r7: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q & ~FMASK) == (RST_VAL & ~FMASK));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RST_VAL;
        end else if (wr.en && !BAD) begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign cfg_err_o = BAD;

    // R9: a rejected configuration keeps the reset word
    p_reject_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> (ctrl_q == RST_VAL));

endmodule

// File: rtl/fcd_ratio_map.sv
module fcd_ratio_map
    import fcd_pkg::*;
#(
    parameter int       SHIFT   = 4,
    parameter int       WIDTH   = 3,
    parameter fcd_enc_e ENC     = ENC_PLUS1,
    parameter int       RW      = 4,
    parameter int       TBL_N   = 4,
    parameter int       TBL_DW  = 8,
    parameter logic [TBL_N*WIDTH-1:0]  TBL_VAL = '0,
    parameter logic [TBL_N*TBL_DW-1:0] TBL_DIV = '0
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [RW-1:0]     ratio_o
);

    logic [CTRL_W-1:0] shifted;
    logic [WIDTH-1:0]  raw;

    assign shifted = ctrl_i >> SHIFT;
    assign raw     = shifted[WIDTH-1:0];

    generate
        if (ENC == ENC_ONEB) begin : g_oneb
            assign ratio_o = RW'(raw);
        end else if (ENC == ENC_POW2) begin : g_pow2
            assign ratio_o = RW'(1) << raw;
        end else if (ENC == ENC_MAXZ) begin : g_maxz
            assign ratio_o = (raw == '0) ? (RW'(1) << WIDTH) : RW'(raw);
        end else if (ENC == ENC_TABLE) begin : g_table
            // Scan from the last entry down so the lowest matching index wins.
            always_comb begin
                ratio_o = '0;
                for (int i = TBL_N - 1; i >= 0; i--) begin
                    if (TBL_VAL[i*WIDTH +: WIDTH] == raw) begin
                        ratio_o = RW'(TBL_DIV[i*TBL_DW +: TBL_DW]);
                    end
                end
            end
        end else begin : g_plus1
            assign ratio_o = RW'(raw) + RW'(1);
        end
    endgenerate

endmodule

// File: rtl/fcd_wave_gen.sv
module fcd_wave_gen #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] ratio_i,
    output logic          div_o,
    output logic          pass_o,
    output logic          zero_o
);

    logic [RW-1:0] act_q, cnt_q;
    logic [RW-1:0] act_n, cnt_n, hi_n;
    logic          q_q, q_n;
    logic          pass, wrap;

    assign pass = (act_q <= RW'(1));
    assign wrap = pass || (cnt_q == act_q - RW'(1));

    always_comb begin
        act_n = wrap ? ratio_i : act_q;
        cnt_n = wrap ? '0 : cnt_q + RW'(1);
        hi_n  = (act_n >> 1) + RW'(act_n[0]);
        q_n   = (cnt_n < hi_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= ratio_i;
            cnt_q <= '0;
            q_q   <= 1'b1;
        end else begin
            act_q <= act_n;
            cnt_q <= cnt_n;
            q_q   <= q_n;
        end
    end

    assign div_o  = q_q;
    assign pass_o = pass;
    assign zero_o = (act_q == '0);

    // R10: the ratio in use only changes as a period restarts
    p_reload_at_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(act_q));

    // R11: phase counter stays inside the period
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        !pass |-> (cnt_q < act_q));

    // R11: every divided period opens with the high phase
    p_start_high_r11: assert property (@(posedge clk) disable iff (rst)
        (!pass && cnt_q == '0) |-> q_q);

endmodule

// File: rtl/fieldclk_div.sv
module fieldclk_div
    import fcd_pkg::*;
#(
    parameter int                SHIFT   = 4,
    parameter int                WIDTH   = 3,
    parameter fcd_enc_e          ENC     = ENC_PLUS1,
    parameter fcd_wmode_e        WMODE   = WR_FIELD,
    parameter logic [CTRL_W-1:0] RST_VAL = 32'hA5A5_0015,
    parameter int                TBL_N   = 4,
    parameter int                TBL_DW  = 8,
    parameter logic [TBL_N*WIDTH-1:0]  TBL_VAL = 12'b110_100_001_000,
    parameter logic [TBL_N*TBL_DW-1:0] TBL_DIV = {8'd12, 8'd6, 8'd3, 8'd2}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        clk_out,
    output logic        zero_div,
    output logic        cfg_err
);

    localparam int RW = ratio_bits(ENC, WIDTH, TBL_DW);

    fcd_wr_t           wr_req;
    logic [CTRL_W-1:0] ctrl;
    logic [RW-1:0]     ratio;
    logic              div_clk, pass;

    assign wr_req.en   = wr_en;
    assign wr_req.data = wr_data;

    fcd_ctrl_reg #(
        .SHIFT(SHIFT), .WIDTH(WIDTH), .WMODE(WMODE), .RST_VAL(RST_VAL)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr(wr_req), .ctrl_o(ctrl), .cfg_err_o(cfg_err)
    );

    fcd_ratio_map #(
        .SHIFT(SHIFT), .WIDTH(WIDTH), .ENC(ENC), .RW(RW),
        .TBL_N(TBL_N), .TBL_DW(TBL_DW), .TBL_VAL(TBL_VAL), .TBL_DIV(TBL_DIV)
    ) u_map (
        .ctrl_i(ctrl), .ratio_o(ratio)
    );

    fcd_wave_gen #(.RW(RW)) u_wave (
        .clk(clk), .rst(rst), .ratio_i(ratio),
        .div_o(div_clk), .pass_o(pass), .zero_o(zero_div)
    );

    assign rd_data = ctrl;
    assign clk_out = pass ? clk : div_clk;

endmodule

// File: tb/fieldclk_div_bench.sv
module fieldclk_div_bench;
    import fcd_pkg::*;

    localparam int NI = 7;
    localparam int NS = 12;
    localparam logic [31:0] STEPS [NS] = '{
        32'h0000_0000, 32'h0070_0010, 32'hFFFF_FF2F, 32'h0010_0070,
        32'h0000_0070, 32'h0070_0050, 32'h0030_0060, 32'h0000_0040,
        32'h0070_0030, 32'h0070_0000, 32'h1234_5678, 32'hABCD_0024
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd [NI];
    logic co [NI];
    logic zd [NI];
    logic ce [NI];

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;

    logic [31:0] m_ctrl [NI];
    int m_act [NI];
    int m_cnt [NI];

    always #5 clk = ~clk;

    fieldclk_div u_fieldclk_div (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[0]), .clk_out(co[0]), .zero_div(zd[0]), .cfg_err(ce[0]));
    fieldclk_div #(.ENC(ENC_ONEB), .RST_VAL(32'h0000_0030)) u_oneb (.clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[1]), .clk_out(co[1]), .zero_div(zd[1]), .cfg_err(ce[1]));
    fieldclk_div #(.ENC(ENC_POW2), .RST_VAL(32'h0000_0020)) u_pow2 (.clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[2]), .clk_out(co[2]), .zero_div(zd[2]), .cfg_err(ce[2]));
    fieldclk_div #(.ENC(ENC_MAXZ), .RST_VAL(32'h0000_0000)) u_maxz (.clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[3]), .clk_out(co[3]), .zero_div(zd[3]), .cfg_err(ce[3]));
    fieldclk_div #(.ENC(ENC_TABLE), .RST_VAL(32'h0000_0010)) u_tbl (.clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[4]), .clk_out(co[4]), .zero_div(zd[4]), .cfg_err(ce[4]));
    fieldclk_div #(.WMODE(WR_HALFMASK), .RST_VAL(32'h5A5A_0035)) u_hw (.clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[5]), .clk_out(co[5]), .zero_div(zd[5]), .cfg_err(ce[5]));
    fieldclk_div #(.WMODE(WR_HALFMASK), .SHIFT(14), .WIDTH(4), .RST_VAL(32'h0000_4000),
        .TBL_VAL(16'h0000), .TBL_DIV(32'h0)) u_bad (.clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[6]), .clk_out(co[6]), .zero_div(zd[6]), .cfg_err(ce[6]));

    // Per-instance configuration as the bench understands it
    function automatic int f_sh(int k);  return (k == 6) ? 14 : 4; endfunction
    function automatic int f_wd(int k);  return (k == 6) ? 4 : 3;  endfunction
    function automatic int f_enc(int k); return (k >= 5) ? 0 : k;  endfunction
    function automatic bit f_hw(int k);  return k >= 5;            endfunction
    function automatic bit f_bad(int k); return k == 6;            endfunction
    function automatic logic [31:0] f_rst(int k);
        case (k)
            0: return 32'hA5A5_0015;
            1: return 32'h0000_0030;
            2: return 32'h0000_0020;
            3: return 32'h0000_0000;
            4: return 32'h0000_0010;
            5: return 32'h5A5A_0035;
            default: return 32'h0000_4000;
        endcase
    endfunction
    function automatic string f_tag(int k);
        case (k)
            0: return "R1 R10 R11";
            1: return "R2 R6";
            2: return "R3";
            3: return "R4";
            4: return "R5 R6";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int f_ratio(int k, logic [31:0] c);
        int raw;
        raw = int'((c >> f_sh(k)) & ((32'd1 << f_wd(k)) - 32'd1));
        case (f_enc(k))
            0: return raw + 1;
            1: return raw;
            2: return 1 << raw;
            3: return (raw == 0) ? (1 << f_wd(k)) : raw;
            default: begin
                if (raw == 0) return 2;
                if (raw == 1) return 3;
                if (raw == 4) return 6;
                if (raw == 6) return 12;
                return 0;
            end
        endcase
    endfunction

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        for (int k = 0; k < NI; k++) begin
            if (rst) begin
                m_ctrl[k] = f_rst(k);
                m_act[k]  = f_ratio(k, f_rst(k));
                m_cnt[k]  = 0;
            end else begin
                if (m_act[k] <= 1 || m_cnt[k] >= m_act[k] - 1) begin
                    m_cnt[k] = 0;
                    m_act[k] = f_ratio(k, m_ctrl[k]);
                end else begin
                    m_cnt[k] = m_cnt[k] + 1;
                end
                if (wr_en && !f_bad(k)) begin
                    if (f_hw(k)) begin
                        for (int i = 0; i < 16; i++)
                            if (wr_data[16+i]) m_ctrl[k][i] = wr_data[i];
                    end else begin
                        logic [31:0] msk;
                        msk = ((32'd1 << f_wd(k)) - 32'd1) << f_sh(k);
                        m_ctrl[k] = (m_ctrl[k] & ~msk) | (wr_data & msk);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int k,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s inst%0d actual %h expected %h at %0t", req, what, k, act, exp, $time);
        end
    endtask

    task automatic compare(input bit high_phase);
        for (int k = 0; k < NI; k++) begin
            logic e_out;
            if (m_act[k] <= 1) e_out = high_phase;
            else e_out = (m_cnt[k] < (m_act[k] + 1) / 2);
            chk(co[k] === e_out, f_tag(k), "clk_out", k, 32'(co[k]), 32'(e_out));
            chk(zd[k] === (m_act[k] == 0), "R6", "zero_div", k, 32'(zd[k]), 32'(m_act[k] == 0));
            chk(ce[k] === f_bad(k), "R9", "cfg_err", k, 32'(ce[k]), 32'(f_bad(k)));
            chk(rd[k] === m_ctrl[k], (k >= 5) ? f_tag(k) : "R7", "rd_data", k, rd[k], m_ctrl[k]);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (chk_on) compare(1'b1);
    end
    always @(negedge clk) begin
        #2;
        if (chk_on) compare(1'b0);
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R12: reset state with reset held
        chk(rd[0] === 32'hA5A5_0015, "R12", "rd_data in reset", 0, rd[0], 32'hA5A5_0015);
        chk(co[0] === 1'b1, "R12", "clk_out in reset", 0, 32'(co[0]), 32'd1);
        chk(zd[0] === 1'b0, "R12", "zero_div in reset", 0, 32'(zd[0]), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = STEPS[s];
            @(negedge clk);
            wr_en = 1'b0;
            // short holds force rewrites in the middle of a period (R10)
            repeat ((s == 3 || s == 4) ? 2 : 140) @(negedge clk);
        end
        chk_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule